// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

This block is a first-in, first-out buffer whose producer and consumer run on separate free-running clocks. A producer offers a word together with two enables. The word is stored only when both enables are high and the buffer reports that it can accept. A consumer removes the word shown on the output register by raising two read enables and the output enable while the output-ready flag is high.

Storage is a memory array of 2^ADDR_W words plus one output register, so the buffer holds one word more than the array. When a word enters an empty buffer it moves into the output register on its own, without any read request. The write and read pointers cross between the clock domains as Gray code through flop chains of fixed length. Because of this, every flag responds a fixed number of edges after the event on the other side.

A synchronous clear, held high for at least four edges of each clock, empties the buffer. Input-ready comes back a fixed number of write clocks after the clear is released.

Top module: `twoclk_fifo`

## Requirements
- R1: A word is stored on a write-clock rising edge only if `wr_en_a`, `wr_en_b` and `wr_ready` are all high at that edge. A write attempt while `wr_ready` is low stores nothing.
- R2: A word is consumed on a read-clock rising edge only if `rd_en_a`, `rd_en_b`, `rd_oe` and `rd_ready` are all high at that edge. If any of them is low, the word stays on `rd_data` and `rd_ready` stays high.
- R3: With SYNC_STAGES = 2, a word written into an empty buffer appears on `rd_data` on the third read-clock rising edge after the write edge. `rd_ready` rises on that same edge, whatever the read enables are. After the second such edge, `rd_ready` is still low.
- R4: `rd_ready` falls on the read-clock edge that consumes the last stored word.
- R5: With SYNC_STAGES = 2, once the buffer is full, `wr_ready` is still low after the first write-clock edge that follows the first consuming read edge, and is high after the second.
- R6: The buffer holds exactly 2^ADDR_W + 1 words. `wr_ready` is low while it holds that many.
- R7: While `clear` is high, `wr_ready` and `rd_ready` are low from the first edge of their own clock onward. Words stored before the clear are discarded and never appear.
- R8: After `clear` falls, `wr_ready` is still low after the first write-clock edge and high after the second.
- R9: `rd_valid` is high exactly when `rd_ready` and `rd_oe` are both high.
- R10: `rd_data` keeps its value across any read-clock edge that consumes nothing while `rd_ready` is high.
- R11: Words leave in the order in which they were stored, with no loss and no duplication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| clear | input | 1 | Synchronous clear, active high, seen by both clocks |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | DATA_W | Word offered for storage |
| wr_ready | output | 1 | Buffer can accept a word |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_oe | input | 1 | Output enable; qualifies reads and `rd_valid` |
| rd_data | output | DATA_W | Output register contents |
| rd_valid | output | 1 | Output word valid and enabled |
| rd_ready | output | 1 | Output register holds a word |

## Verification
The bench builds the block with DATA_W = 18, ADDR_W = 4 and SYNC_STAGES = 2. The small array brings the full condition (17 words) within a few dozen write clocks, so the input-ready recovery and the rejection of writes while full are exercised many times in the random phase. The two clocks are 8 ns and 11 ns, and their edges never coincide, which makes the fixed two- and three-edge latencies countable from the ports.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    // write-side request: both enables must be high
    typedef struct packed {
        logic en_a;
        logic en_b;
    } wr_req_t;

    // read-side request: both enables plus output enable
    typedef struct packed {
        logic en_a;
        logic en_b;
        logic oe;
    } rd_req_t;

    function automatic logic wr_go(input wr_req_t q, input logic ready);
        return q.en_a & q.en_b & ready;
    endfunction

    function automatic logic rd_go(input rd_req_t q, input logic ready);
        return q.en_a & q.en_b & q.oe & ready;
    endfunction

endpackage

// File: rtl/tcf_sync.sv
module tcf_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (clr)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tcf_mem.sv
module tcf_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/tcf_wr_side.sv
module tcf_wr_side
    import tcf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              clr,
    input  wr_req_t           req,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              ready,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [1:0]    live;
    logic          full;

    // full when the write pointer is one whole array ahead of the seen read pointer
    assign full    = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign ready   = live[1] & ~full;
    assign we      = wr_go(req, ready);
    assign waddr   = wbin[ADDR_W-1:0];
    assign wbin_nx = wbin + PW'(1);

    always_ff @(posedge clk) begin
        if (clr) begin
            wbin  <= '0;
            wgray <= '0;
            live  <= '0;
        end else begin
            live <= {live[0], 1'b1};
            if (we) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end
endmodule

// File: rtl/tcf_rd_side.sv
module tcf_rd_side
    import tcf_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              clr,
    input  rd_req_t           req,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              ready,
    output logic [DATA_W-1:0] dout
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic          array_empty;
    logic          take;
    logic          load;

    assign array_empty = (rgray == wgray_s);
    assign take        = rd_go(req, ready);
    assign load        = ~array_empty & (~ready | take);
    assign raddr       = rbin[ADDR_W-1:0];
    assign rbin_nx     = rbin + PW'(1);

    always_ff @(posedge clk) begin
        if (clr) begin
            rbin  <= '0;
            rgray <= '0;
            ready <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            dout  <= rdata;
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            ready <= 1'b1;
        end else if (take) begin
            ready <= 1'b0;
        end
    end
endmodule

// File: rtl/twoclk_fifo.sv
module twoclk_fifo
    import tcf_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              clear,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic              rd_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_ready
);
    localparam int PW = ADDR_W + 1;

    wr_req_t           wreq;
    rd_req_t           rreq;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] mem_q;
    logic [PW-1:0]     wr_gray;
    logic [PW-1:0]     rd_gray;
    logic [PW-1:0]     wr_gray_rs;
    logic [PW-1:0]     rd_gray_ws;

    assign wreq = '{en_a: wr_en_a, en_b: wr_en_b};
    assign rreq = '{en_a: rd_en_a, en_b: rd_en_b, oe: rd_oe};

    tcf_wr_side #(.ADDR_W(ADDR_W)) i_wr (
        .clk(wr_clk), .clr(clear), .req(wreq), .rgray_s(rd_gray_ws),
        .ready(wr_ready), .we(we), .waddr(waddr), .wgray(wr_gray)
    );

    tcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    tcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) i_w2r (
        .clk(rd_clk), .clr(clear), .d(wr_gray), .q(wr_gray_rs)
    );

    tcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) i_r2w (
        .clk(wr_clk), .clr(clear), .d(rd_gray), .q(rd_gray_ws)
    );

    tcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd (
        .clk(rd_clk), .clr(clear), .req(rreq), .wgray_s(wr_gray_rs),
        .rdata(mem_q), .raddr(raddr), .rgray(rd_gray),
        .ready(rd_ready), .dout(rd_data)
    );

    assign rd_valid = rd_ready & rd_oe;
endmodule

// File: rtl/twoclk_fifo_chk.sv
module twoclk_fifo_chk #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              clear,
    input logic              wr_ready,
    input logic              rd_en_a,
    input logic              rd_en_b,
    input logic              rd_oe,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W:0]   wr_gray,
    input logic [ADDR_W:0]   rd_gray,
    input logic [ADDR_W:0]   wr_gray_rs
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW-2; i >= 0; i--)
            b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic          take;
    logic [PW-1:0] occ;

    assign take = rd_en_a & rd_en_b & rd_oe & rd_ready;
    assign occ  = g2b(wr_gray_rs) - g2b(rd_gray);

    // R1
    blocked_write_chk: assert property (@(posedge wr_clk) disable iff (clear)
        !wr_ready |=> $stable(wr_gray));

    // R11
    gray_step_chk: assert property (@(posedge wr_clk) disable iff (clear)
        $onehot0(wr_gray ^ $past(wr_gray)));

    // R6
    occupancy_limit_chk: assert property (@(posedge rd_clk) disable iff (clear)
        occ <= PW'(DEPTH));

    // R2
    no_take_chk: assert property (@(posedge rd_clk) disable iff (clear)
        (rd_ready && !take) |=> rd_ready);

    // R4
    last_word_drop_chk: assert property (@(posedge rd_clk) disable iff (clear)
        (take && wr_gray_rs == rd_gray) |=> !rd_ready);

    // R10
    data_hold_chk: assert property (@(posedge rd_clk) disable iff (clear)
        (rd_ready && !take) |=> $stable(rd_data));
endmodule

bind twoclk_fifo twoclk_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .clear(clear), .wr_ready(wr_ready),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_oe(rd_oe), .rd_ready(rd_ready),
    .rd_data(rd_data), .wr_gray(wr_gray), .rd_gray(rd_gray),
    .wr_gray_rs(wr_gray_rs)
);

// File: tb/test_twoclk_fifo.sv
module test_twoclk_fifo;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DATA_W = 18;
    localparam int ADDR_W = 4;
    localparam int CAP    = (1 << ADDR_W) + 1;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              clear  = 1'b1;
    logic              wr_en_a = 1'b0, wr_en_b = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_ready;
    logic              rd_en_a = 1'b0, rd_en_b = 1'b0, rd_oe = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              rd_ready;

    int n_chk = 0;
    int n_err = 0;
    logic [DATA_W-1:0] sb [$];
    logic wdone;

    twoclk_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_twoclk_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .clear(clear),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_oe(rd_oe),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    always #4   wr_clk = ~wr_clk;
    always #5.5 rd_clk = ~rd_clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic wants(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    task automatic do_clear();
        @(negedge wr_clk);
        clear = 1'b1;
        wr_en_a = 1'b0; wr_en_b = 1'b0;
        rd_en_a = 1'b0; rd_en_b = 1'b0; rd_oe = 1'b0;
        repeat (8) @(posedge wr_clk);
        #1;
        chk("R7 wr_ready in clear", 32'(wr_ready), 0);
        chk("R7 rd_ready in clear", 32'(rd_ready), 0);
        sb.delete();
        @(negedge wr_clk);
        clear = 1'b0;
        @(posedge wr_clk); #1;
        chk("R8 wr_ready after 1st edge", 32'(wr_ready), 0);
        @(posedge wr_clk); #1;
        chk("R8 wr_ready after 2nd edge", 32'(wr_ready), 1);
    endtask

    // watchdog
    initial begin
        #(200000 * 8);
        n_err++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unused;
        int accepted;
        unused = $urandom(32'h00c0ffee);
        wdone = 1'b0;

        // ---------- R3 / R4: fall-through latency ----------
        do_clear();
        @(negedge rd_clk);
        rd_en_a = 1'b1; rd_en_b = 1'b1; rd_oe = 1'b1;
        @(negedge wr_clk);
        wr_en_a = 1'b1; wr_en_b = 1'b1; wr_data = 18'h2a5c3;
        @(posedge wr_clk);
        fork
            begin @(negedge wr_clk); wr_en_a = 1'b0; wr_en_b = 1'b0; end
        join_none
        repeat (2) @(posedge rd_clk);
        #1 chk("R3 rd_ready after 2nd read edge", 32'(rd_ready), 0);
        @(posedge rd_clk);
        #1 chk("R3 rd_ready after 3rd read edge", 32'(rd_ready), 1);
        chk("R3 first word on output", 32'(rd_data), 32'h2a5c3);
        chk("R9 rd_valid with oe high", 32'(rd_valid), 1);
        @(posedge rd_clk);
        #1 chk("R4 rd_ready after last read", 32'(rd_ready), 0);

        // ---------- R7: contents discarded ----------
        @(negedge rd_clk);
        rd_en_a = 1'b0; rd_en_b = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge wr_clk);
            wr_en_a = 1'b1; wr_en_b = 1'b1; wr_data = 18'(i + 100);
        end
        @(negedge wr_clk);
        wr_en_a = 1'b0; wr_en_b = 1'b0;
        do_clear();
        repeat (10) @(posedge rd_clk);
        #1 chk("R7 nothing survives clear", 32'(rd_ready), 0);

        // ---------- R6 / R1 / R5: fill past capacity ----------
        accepted = 0;
        rd_oe = 1'b1;
        for (int i = 0; i < 24; i++) begin
            @(negedge wr_clk);
            wr_en_a = 1'b1; wr_en_b = 1'b1; wr_data = 18'(i);
            if (wr_ready) begin
                sb.push_back(18'(i));
                accepted++;
            end
        end
        @(negedge wr_clk);
        wr_en_a = 1'b0; wr_en_b = 1'b0;
        repeat (10) @(posedge wr_clk);
        #1;
        chk("R6 words accepted", 32'(accepted), 32'(CAP));
        chk("R6 wr_ready low when full", 32'(wr_ready), 0);

        // R2 / R9: partial enables do not consume
        @(negedge rd_clk);
        rd_en_a = 1'b1; rd_en_b = 1'b1; rd_oe = 1'b0;
        #1 chk("R9 rd_valid with oe low", 32'(rd_valid), 0);
        @(posedge rd_clk);
        @(negedge rd_clk);
        chk("R2 oe low keeps word", 32'(rd_data), 32'(sb[0]));
        rd_en_b = 1'b0; rd_oe = 1'b1;
        @(posedge rd_clk);
        @(negedge rd_clk);
        chk("R2 enable low keeps ready", 32'(rd_ready), 1);
        chk("R10 data held", 32'(rd_data), 32'(sb[0]));

        // R5: single read, then count write edges
        rd_en_b = 1'b1;
        chk("R11 head word", 32'(rd_data), 32'(sb.pop_front()));
        @(posedge rd_clk);
        fork
            begin @(negedge rd_clk); rd_en_a = 1'b0; end
        join_none
        @(posedge wr_clk); #1;
        chk("R5 wr_ready after 1st write edge", 32'(wr_ready), 0);
        @(posedge wr_clk); #1;
        chk("R5 wr_ready after 2nd write edge", 32'(wr_ready), 1);

        // drain
        while (sb.size() > 0) begin
            @(negedge rd_clk);
            rd_en_a = 1'b1; rd_en_b = 1'b1; rd_oe = 1'b1;
            chk("R11 drain ready", 32'(rd_ready), 1);
            chk("R11 drain order", 32'(rd_data), 32'(sb.pop_front()));
            @(posedge rd_clk);
        end
        #1 chk("R4 empty after drain", 32'(rd_ready), 0);
        repeat (10) @(posedge rd_clk);
        #1 chk("R1 rejected writes not stored", 32'(rd_ready), 0);

        // ---------- random traffic ----------
        do_clear();
        fork
            begin : writer
                for (int c = 0; c < 3000; c++) begin
                    @(negedge wr_clk);
                    wr_en_a = wants(85);
                    wr_en_b = wants(85);
                    wr_data = 18'($urandom);
                    if (wr_en_a && wr_en_b && wr_ready)
                        sb.push_back(wr_data);
                end
                @(negedge wr_clk);
                wr_en_a = 1'b0; wr_en_b = 1'b0;
                wdone = 1'b1;
            end
            begin : reader
                logic              p_rdy;
                logic              p_take;
                logic [DATA_W-1:0] p_dat;
                int                pct;
                p_rdy = 1'b0; p_take = 1'b0; p_dat = '0;
                for (int c = 0; c < 6000; c++) begin
                    @(negedge rd_clk);
                    chk("R9 rd_valid", 32'(rd_valid), 32'(rd_ready & rd_oe));
                    if (rd_ready && sb.size() == 0)
                        chk("R11 ready without data", 32'(rd_ready), 0);
                    if (p_rdy && !p_take && rd_ready)
                        chk("R10 hold without read", 32'(rd_data), 32'(p_dat));
                    pct = wdone ? 95 : ((c / 500) % 2 == 0 ? 60 : 85);
                    rd_en_a = wants(pct);
                    rd_en_b = wants(pct);
                    rd_oe   = wants(pct);
                    p_take  = rd_en_a & rd_en_b & rd_oe & rd_ready;
                    p_rdy   = rd_ready;
                    p_dat   = rd_data;
                    if (p_take && sb.size() > 0)
                        chk("R11 random order", 32'(rd_data), 32'(sb.pop_front()));
                end
            end
        join
        @(negedge rd_clk);
        rd_en_a = 1'b0; rd_en_b = 1'b0; rd_oe = 1'b0;
        chk("R11 all words delivered", 32'(sb.size()), 0);
        chk("R4 empty at end", 32'(rd_ready), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule